// File: doc/BRIEF.md
# System Call Trap State Update

This block is the combinational core of a trap unit in a 64-bit processor. When the decoded operation is a system call, it works out in one pass all the state the trap must commit: the return address to save, the saved copy of the machine state, the new machine state and the redirect target. Each result comes with a valid flag for the writeback logic downstream. When the operation is a return from interrupt, it produces only the redirect target, taken from the saved return address and word-aligned.

The saved state and the new machine state are not plain copies of the incoming machine state. Each bit follows a fixed rule. Some bits are copied, some are cleared, and the 64-bit-mode and little-endian bits are always set. Bits are numbered here from 0 at the most significant end, so bit n sits at vector index 63-n.

A context tag travels through the block unchanged, so the surrounding pipeline can match results to their requests. No register sits between the inputs and the outputs.

Top module: `trap_sc_unit`

## Requirements
- R1: For a system call (op_i = 2'b01), srr0_o equals cia_i + 4, taken modulo 2^64.
- R2: For a system call, srr1_o bits 33 to 36 and bits 42 to 47 (MSB-0 numbering, which is vector indices 30:27 and 21:16) are zero.
- R3: For a system call, every other srr1_o bit (MSB-0 bits 0 to 32, 37 to 41 and 48 to 63) equals the same bit of msr_i.
- R4: For a system call, msr_o clears these bits, given as MSB-0 positions: TM 31, VEC 38, VSX 40, EE 48, PR 49, FP 50, FE0 52, TE 53 to 54, FE1 55, IR 58, DR 59, PMM 61, RI 62. Together they form the clear mask 64'h0000_0001_0280_EF36.
- R5: For a system call, msr_o sets SF (MSB-0 bit 0, vector index 63) and LE (MSB-0 bit 63, vector index 0) to 1. All bits not named in R4 or R5 are copied from msr_i.
- R6: For a system call, srr0_vld_o, srr1_vld_o, msr_vld_o and nia_vld_o are all 1.
- R7: For a system call, nia_o equals tvec_i shifted left by 4 bits, with zeros in the low 4 bits.
- R8: For a return from interrupt (op_i = 2'b10), nia_o equals srr0_i with bits 1:0 forced to zero and nia_vld_o is 1. srr0_o, srr1_o and msr_o are zero and their valid flags are 0.
- R9: ctx_o equals ctx_i in the same cycle for every value of op_i.
- R10: For op_i = 2'b00 or 2'b11, all valid flags are 0 and srr0_o, srr1_o, msr_o and nia_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | Operation: 00 idle, 01 system call, 10 return from interrupt, 11 idle |
| cia_i | input | 64 | Address of the current instruction |
| msr_i | input | 64 | Incoming machine state |
| tvec_i | input | 60 | Trap vector, in units of 16 bytes |
| srr0_i | input | 64 | Saved return address, used by a return from interrupt |
| ctx_i | input | 8 | Context tag |
| srr0_o | output | 64 | Return address to save |
| srr0_vld_o | output | 1 | srr0_o is to be written |
| srr1_o | output | 64 | Saved machine state to write |
| srr1_vld_o | output | 1 | srr1_o is to be written |
| msr_o | output | 64 | New machine state |
| msr_vld_o | output | 1 | msr_o is to be written |
| nia_o | output | 64 | Next instruction address |
| nia_vld_o | output | 1 | nia_o is a redirect |
| ctx_o | output | 8 | Context tag, passed through |

## Verification
The block holds no state, so any fault in a bit rule or in the operation decode shows at the ports in the same cycle as the input that exposes it. A rule assigned to the wrong bit only shows when msr_i holds the opposite value at that bit. For that reason the machine-state inputs include all-ones, all-zeros, alternating patterns and random values, so that each bit's copy, clear or set is seen in both polarities. The address carry wrap, the forced alignment bits on return and the reserved operation code are each driven directly.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int XLEN = 64;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'b00,
        OP_SYSCALL = 2'b01,
        OP_RETURN  = 2'b10,
        OP_RSVD    = 2'b11
    } trap_op_e;

    typedef enum logic [1:0] {
        RULE_KEEP  = 2'd0,
        RULE_CLEAR = 2'd1,
        RULE_SET   = 2'd2
    } bit_rule_e;

    typedef struct packed {
        logic [XLEN-1:0] data;
        logic            vld;
    } word_out_t;

    // Machine-state bit positions, numbered from 0 at the MSB
    localparam int POS_SF  = 0;
    localparam int POS_TM  = 31;
    localparam int POS_VEC = 38;
    localparam int POS_VSX = 40;
    localparam int POS_EE  = 48;
    localparam int POS_PR  = 49;
    localparam int POS_FP  = 50;
    localparam int POS_FE0 = 52;
    localparam int POS_TEA = 53;
    localparam int POS_TEB = 54;
    localparam int POS_FE1 = 55;
    localparam int POS_IR  = 58;
    localparam int POS_DR  = 59;
    localparam int POS_PMM = 61;
    localparam int POS_RI  = 62;
    localparam int POS_LE  = 63;

    // Saved-state cleared ranges, numbered from 0 at the MSB
    localparam int SAVE_Z0_LO = 33;
    localparam int SAVE_Z0_HI = 36;
    localparam int SAVE_Z1_LO = 42;
    localparam int SAVE_Z1_HI = 47;

    function automatic int vec_idx(input int pos);
        return XLEN - 1 - pos;
    endfunction

    function automatic bit_rule_e state_rule(input int pos);
        bit_rule_e r;
        case (pos)
            POS_SF, POS_LE: r = RULE_SET;
            POS_TM, POS_VEC, POS_VSX, POS_EE, POS_PR, POS_FP,
            POS_FE0, POS_TEA, POS_TEB, POS_FE1, POS_IR, POS_DR,
            POS_PMM, POS_RI: r = RULE_CLEAR;
            default: r = RULE_KEEP;
        endcase
        return r;
    endfunction

    function automatic bit save_zeroed(input int pos);
        return ((pos >= SAVE_Z0_LO) && (pos <= SAVE_Z0_HI)) ||
               ((pos >= SAVE_Z1_LO) && (pos <= SAVE_Z1_HI));
    endfunction

endpackage

// File: rtl/trap_srr1_build.sv
module trap_srr1_build
    import trap_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] msr_i,
    output logic [W-1:0] srr1_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam bit ZERO = save_zeroed(W - 1 - i);
        if (ZERO) begin : g_zero
            assign srr1_o[i] = 1'b0;
        end else begin : g_copy
            assign srr1_o[i] = msr_i[i];
        end
    end

endmodule

// File: rtl/trap_msr_build.sv
module trap_msr_build
    import trap_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] msr_i,
    output logic [W-1:0] msr_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam bit_rule_e RULE = state_rule(W - 1 - i);
        if (RULE == RULE_SET) begin : g_set
            assign msr_o[i] = 1'b1;
        end else if (RULE == RULE_CLEAR) begin : g_clr
            assign msr_o[i] = 1'b0;
        end else begin : g_keep
            assign msr_o[i] = msr_i[i];
        end
    end

    // R5: mode bits forced on regardless of the incoming state
    always_comb begin
        p_mode_forced_r5: assert (msr_o[vec_idx(POS_SF)] && msr_o[vec_idx(POS_LE)])
            else $error("new state lacks 64-bit or little-endian mode");
    end

    // R4: privilege and interrupt enables come out cleared
    always_comb begin
        p_priv_cleared_r4: assert (!msr_o[vec_idx(POS_PR)] && !msr_o[vec_idx(POS_EE)] &&
                                   !msr_o[vec_idx(POS_IR)] && !msr_o[vec_idx(POS_DR)])
            else $error("new state keeps privilege or translation bits");
    end

endmodule

// File: rtl/trap_nia_sel.sv
module trap_nia_sel
    import trap_pkg::*;
#(
    parameter int W         = XLEN,
    parameter int TVEC_W    = 60,
    parameter int ALIGN_LSB = 2
) (
    input  trap_op_e     op_i,
    input  logic [TVEC_W-1:0] tvec_i,
    input  logic [W-1:0] srr0_i,
    output word_out_t    nia_o
);

    localparam int SHIFT = W - TVEC_W;

    logic [W-1:0] vec_target;
    logic [W-1:0] ret_target;

    assign vec_target = {tvec_i, {SHIFT{1'b0}}};
    assign ret_target = {srr0_i[W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};

    always_comb begin
        nia_o = '0;
        case (op_i)
            OP_SYSCALL: nia_o = '{data: vec_target, vld: 1'b1};
            OP_RETURN:  nia_o = '{data: ret_target, vld: 1'b1};
            default:    nia_o = '0;
        endcase
    end

    // R7: the vector redirect lands on a 16-byte boundary
    always_comb begin
        if (op_i == OP_SYSCALL)
            p_vec_aligned_r7: assert (nia_o.vld && nia_o.data[SHIFT-1:0] == '0)
                else $error("vector redirect misaligned");
    end

    // R8: the return target is word aligned and its upper part follows srr0_i
    always_comb begin
        if (op_i == OP_RETURN)
            p_ret_aligned_r8: assert (nia_o.vld && nia_o.data[ALIGN_LSB-1:0] == '0 &&
                                      nia_o.data[W-1:ALIGN_LSB] == srr0_i[W-1:ALIGN_LSB])
                else $error("return target wrong");
    end

endmodule

// File: rtl/trap_sc_unit.sv
module trap_sc_unit
    import trap_pkg::*;
#(
    parameter int TVEC_W   = 60,
    parameter int CTX_W    = 8,
    parameter int RET_STEP = 4
) (
    input  logic [1:0]        op_i,
    input  logic [XLEN-1:0]   cia_i,
    input  logic [XLEN-1:0]   msr_i,
    input  logic [TVEC_W-1:0] tvec_i,
    input  logic [XLEN-1:0]   srr0_i,
    input  logic [CTX_W-1:0]  ctx_i,
    output logic [XLEN-1:0]   srr0_o,
    output logic              srr0_vld_o,
    output logic [XLEN-1:0]   srr1_o,
    output logic              srr1_vld_o,
    output logic [XLEN-1:0]   msr_o,
    output logic              msr_vld_o,
    output logic [XLEN-1:0]   nia_o,
    output logic              nia_vld_o,
    output logic [CTX_W-1:0]  ctx_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(RET_STEP);

    trap_op_e      op;
    logic          is_sc;
    logic [XLEN-1:0] srr1_raw;
    logic [XLEN-1:0] msr_raw;
    word_out_t     nia_w;

    assign op    = trap_op_e'(op_i);
    assign is_sc = (op == OP_SYSCALL);

    trap_srr1_build #(.W(XLEN)) u_srr1 (
        .msr_i  (msr_i),
        .srr1_o (srr1_raw)
    );

    trap_msr_build #(.W(XLEN)) u_msr (
        .msr_i (msr_i),
        .msr_o (msr_raw)
    );

    trap_nia_sel #(.W(XLEN), .TVEC_W(TVEC_W), .ALIGN_LSB(2)) u_nia (
        .op_i   (op),
        .tvec_i (tvec_i),
        .srr0_i (srr0_i),
        .nia_o  (nia_w)
    );

    always_comb begin
        srr0_o     = is_sc ? (cia_i + STEP) : '0;
        srr1_o     = is_sc ? srr1_raw : '0;
        msr_o      = is_sc ? msr_raw : '0;
        srr0_vld_o = is_sc;
        srr1_vld_o = is_sc;
        msr_vld_o  = is_sc;
        nia_o      = nia_w.data;
        nia_vld_o  = nia_w.vld;
    end

    assign ctx_o = ctx_i;

    // R1: saved address is one step past the current instruction
    always_comb begin
        if (srr0_vld_o)
            p_srr0_step_r1: assert (srr0_o - cia_i == STEP)
                else $error("saved address not current plus step");
    end

    // R2: cleared ranges of the saved state
    always_comb begin
        if (srr1_vld_o)
            p_srr1_zero_r2: assert (srr1_o[vec_idx(SAVE_Z0_LO):vec_idx(SAVE_Z0_HI)] == '0 &&
                                    srr1_o[vec_idx(SAVE_Z1_LO):vec_idx(SAVE_Z1_HI)] == '0)
                else $error("saved state cleared range not zero");
    end

    // R3: copied ranges of the saved state
    always_comb begin
        if (srr1_vld_o)
            p_srr1_keep_r3: assert (
                srr1_o[XLEN-1:vec_idx(SAVE_Z0_LO-1)] == msr_i[XLEN-1:vec_idx(SAVE_Z0_LO-1)] &&
                srr1_o[vec_idx(SAVE_Z0_HI+1):vec_idx(SAVE_Z1_LO-1)] ==
                    msr_i[vec_idx(SAVE_Z0_HI+1):vec_idx(SAVE_Z1_LO-1)] &&
                srr1_o[vec_idx(SAVE_Z1_HI+1):0] == msr_i[vec_idx(SAVE_Z1_HI+1):0])
                else $error("saved state copy range differs");
    end

    // R6: the three state writes are issued together with the redirect
    always_comb begin
        p_vld_group_r6: assert (srr0_vld_o == srr1_vld_o && srr1_vld_o == msr_vld_o &&
                                (!msr_vld_o || nia_vld_o))
            else $error("valid flags disagree");
    end

    // R10: with no redirect, nothing is written and all data is zero
    always_comb begin
        if (!nia_vld_o)
            p_idle_quiet_r10: assert (!srr0_vld_o && srr0_o == '0 && srr1_o == '0 &&
                                      msr_o == '0 && nia_o == '0)
                else $error("idle outputs not quiet");
    end

endmodule

// File: tb/tb_trap_sc_unit.sv
module tb_trap_sc_unit;

    localparam logic [63:0] CLR_MASK  = 64'h0000_0001_0280_EF36;
    localparam logic [63:0] SET_MASK  = 64'h8000_0000_0000_0001;
    localparam logic [63:0] SAVE_ZERO = 64'h0000_0000_783F_0000;

    typedef struct {
        logic [1:0]  op;
        logic [63:0] cia;
        logic [63:0] msr;
        logic [63:0] srr0;
        logic [7:0]  ctx;
        logic [59:0] tvec;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [1:0]  op_i   = 2'b00;
    logic [63:0] cia_i  = '0;
    logic [63:0] msr_i  = '0;
    logic [59:0] tvec_i = '0;
    logic [63:0] srr0_i = '0;
    logic [7:0]  ctx_i  = '0;
    logic [63:0] srr0_o, srr1_o, msr_o, nia_o;
    logic        srr0_vld_o, srr1_vld_o, msr_vld_o, nia_vld_o;
    logic [7:0]  ctx_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    item_t q[$];

    trap_sc_unit dut (
        .op_i(op_i), .cia_i(cia_i), .msr_i(msr_i), .tvec_i(tvec_i),
        .srr0_i(srr0_i), .ctx_i(ctx_i),
        .srr0_o(srr0_o), .srr0_vld_o(srr0_vld_o),
        .srr1_o(srr1_o), .srr1_vld_o(srr1_vld_o),
        .msr_o(msr_o), .msr_vld_o(msr_vld_o),
        .nia_o(nia_o), .nia_vld_o(nia_vld_o),
        .ctx_o(ctx_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [63:0] cia, input logic [63:0] msr,
                         input logic [59:0] tvec, input logic [63:0] srr0, input logic [7:0] ctx);
        item_t it;
        @(negedge clk);
        op_i = op; cia_i = cia; msr_i = msr; tvec_i = tvec; srr0_i = srr0; ctx_i = ctx;
        it.op = op; it.cia = cia; it.msr = msr; it.tvec = tvec; it.srr0 = srr0; it.ctx = ctx;
        q.push_back(it);
    endtask

    always @(posedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            chk("R9 ctx", {56'd0, ctx_o}, {56'd0, e.ctx});
            if (e.op == 2'b01) begin
                chk("R1 srr0", srr0_o, e.cia + 64'd4);
                chk("R2 srr1 zero ranges", srr1_o & SAVE_ZERO, 64'd0);
                chk("R3 srr1 copy ranges", srr1_o & ~SAVE_ZERO, e.msr & ~SAVE_ZERO);
                chk("R4 msr cleared bits", msr_o & CLR_MASK, 64'd0);
                chk("R5 msr forced and kept bits", msr_o & ~CLR_MASK,
                    (e.msr & ~CLR_MASK) | SET_MASK);
                chk("R6 valid flags", {60'd0, srr0_vld_o, srr1_vld_o, msr_vld_o, nia_vld_o},
                    64'hF);
                chk("R7 nia vector", nia_o, {e.tvec, 4'h0});
            end else if (e.op == 2'b10) begin
                chk("R8 nia return", nia_o, {e.srr0[63:2], 2'b00});
                chk("R8 valid flags", {60'd0, srr0_vld_o, srr1_vld_o, msr_vld_o, nia_vld_o},
                    64'h1);
                chk("R8 data zero", srr0_o | srr1_o | msr_o, 64'd0);
            end else begin
                chk("R10 valid flags", {60'd0, srr0_vld_o, srr1_vld_o, msr_vld_o, nia_vld_o},
                    64'h0);
                chk("R10 data zero", srr0_o | srr1_o | msr_o | nia_o, 64'd0);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset-time idle state (R10)
        drive(2'b00, 64'h1234, '1, '1, '1, 8'h11);
        // system call, machine state in both polarities (R1..R7)
        drive(2'b01, 64'h0000_0000_0000_1000, '1, 60'h0000_0000_0000_00C, 64'd0, 8'h22);
        drive(2'b01, 64'h0000_0000_0000_2000, '0, 60'h0FF_FFFF_FFFF_FFFF, 64'd0, 8'h33);
        drive(2'b01, 64'h0000_0000_0000_3000, 64'hAAAA_AAAA_AAAA_AAAA, 60'h123, 64'd0, 8'h44);
        drive(2'b01, 64'h0000_0000_0000_3004, 64'h5555_5555_5555_5555, 60'h456, 64'd0, 8'h45);
        // address wrap (R1)
        drive(2'b01, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 60'h1, 64'd0, 8'h55);
        drive(2'b01, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 60'h1, 64'd0, 8'h56);
        // return with low bits set (R8)
        drive(2'b10, '1, '1, '1, 64'hDEAD_BEEF_CAFE_F00F, 8'h66);
        drive(2'b10, '0, '0, '0, 64'h0000_0000_0000_0003, 8'h67);
        // reserved code is idle (R10)
        drive(2'b11, '1, '1, '1, '1, 8'h77);
        for (int i = 0; i < 60; i++) begin
            drive(2'(i % 4), {$urandom, $urandom}, {$urandom, $urandom},
                  {28'($urandom), $urandom}, {$urandom, $urandom}, 8'($urandom));
        end
        drive(2'b00, '0, '0, '0, '0, 8'h00);
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule